// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into characters. It is paced by a baud tick that some other logic supplies, at sixteen ticks per bit. A falling edge on the idle-high line starts a frame. The start bit is confirmed at its midpoint. The data bits follow, least significant first, then an optional parity bit and one stop bit. Each bit is sampled at its centre. A two-bit format input selects 8, 7 or 9 data bits. A fourth code selects 9-bit frames and takes the line from the local transmitter's serial output instead of the pin.

Each good character goes into a one-deep receive buffer, and a buffer-full flag is raised. A buffer read strobe empties the buffer. Four sticky error flags are kept: overrun, framing, parity and break. A status read strobe clears all four, and a combined error output is high while any of them is set. In attention mode, characters whose ninth bit is clear are thrown away. The first character whose ninth bit is set is kept, and it ends attention mode. A receive-active output marks a line held low after a bad stop bit. A receive interrupt request is raised when the buffer is full and the interrupt is enabled.

Top module: `async_rx_core`

## Requirements
- R1: `fmt_sel` selects the data length: 00 gives 8 bits, 01 gives 7 bits and 10 gives 9 bits. The data bits follow the start bit, least significant first. After them come an optional parity bit and one stop bit, and every bit is sampled at its centre with 16 `baud_tick` pulses per bit. `rx_data` holds data bits 0..7, with bit 7 zero in 7-bit format. `rx_bit9` holds data bit 8, which is zero outside the 9-bit formats.
- R2: With `fmt_sel` = 11 the receiver uses 9-bit frames and reads `tx_loop` in place of `rx_pin`, and `rx_pin` has no effect.
- R3: A low pulse on the idle line that is high again at the start bit's midpoint (8 ticks after it was first seen) is dropped, and no character and no flag results.
- R4: A stored character sets `buf_full`, and a `buf_rd` strobe clears it on the next clock. If a character is stored in the same cycle as `buf_rd`, the new character replaces the old one, `buf_full` stays 1 and no overrun is flagged.
- R5: If a character completes while `buf_full` is 1 and no `buf_rd` is given, `ovr_err` is set and `rx_data`/`rx_bit9` keep the old character.
- R6: A stop bit sampled low in a frame that is not all zero sets `frm_err`, and the character is still stored.
- R7: With `par_en` = 1 a parity bit follows the data. It is even parity when `par_odd` = 0 and odd parity when `par_odd` = 1, counted over the data bits and the parity bit. A mismatch sets `par_err`, and the character is still stored.
- R8: A frame in which every data, parity and stop bit is low sets `brk_det`. No character is stored and `frm_err` is not set.
- R9: A `stat_rd` strobe clears `ovr_err`, `frm_err`, `par_err` and `brk_det` on the next clock. A flag whose event falls in the same cycle as the read stays set. Reset clears all four.
- R10: `err_any` is high exactly while at least one of the four error flags is set.
- R11: An `attn_wr` strobe loads `attn_wdata` into `attn_mode`. While `attn_mode` is 1, characters with data bit 8 clear are not stored. A character with data bit 8 set is stored and clears `attn_mode`.
- R12: `rx_active` rises after a framing error or a break and falls once the line is high. The receiver starts no new frame until the line has returned high.
- R13: `rx_irq` is high exactly when `buf_full` and `rx_int_en` are both 1.
- R14: After reset `buf_full`, every error flag, `attn_mode`, `rx_active`, `rx_irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| rx_pin | input | 1 | Serial receive line from the pad |
| tx_loop | input | 1 | Local transmitter serial output, used in loopback |
| fmt_sel | input | 2 | Frame format: 00 8-bit, 01 7-bit, 10 9-bit, 11 9-bit loopback |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| rx_int_en | input | 1 | Receive interrupt enable |
| buf_rd | input | 1 | Receive buffer read strobe |
| stat_rd | input | 1 | Status read strobe, clears error flags |
| attn_wr | input | 1 | Attention mode write strobe |
| attn_wdata | input | 1 | Value written to attention mode |
| rx_data | output | 8 | Buffered data bits 0..7 |
| rx_bit9 | output | 1 | Buffered data bit 8 |
| buf_full | output | 1 | Receive buffer holds an unread character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| brk_det | output | 1 | Line break flag |
| err_any | output | 1 | Any error flag set |
| attn_mode | output | 1 | Attention mode active |
| rx_active | output | 1 | Line held low after a bad stop bit or break |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A character can finish in the same cycle as a buffer read, and also in the same cycle as a status read. The bench first sends a probe frame aligned to a fixed baud tick phase and records the negedge at which `buf_full` rises. It then repeats the frame with the same alignment and asserts the strobe in the cycle that ends at the loading edge. For the buffer read, the check is that the new character is present, `buf_full` is still set and `ovr_err` is clear. For the status read, a framing-error frame is used, and `frm_err` must remain set after the coincident read.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  localparam int unsigned MAX_BITS = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                par_bad;
    logic                stop_bad;
    logic                brk;
  } rx_char_t;

  // number of data bits for a format code
  function automatic logic [3:0] fmt_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd8;
      2'b01:   return 4'd7;
      default: return 4'd9;
    endcase
  endfunction

  // value the parity bit must carry for the given data
  function automatic logic calc_parity(input logic [MAX_BITS-1:0] d,
                                       input logic [3:0] n,
                                       input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < int'(n)) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic pin_in,
  input  logic loop_in,
  output logic line_o
);

  logic              src;
  logic [STAGES-1:0] sh;

  assign src    = loop_en ? loop_in : pin_in;
  assign line_o = sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], src};
  end

  // R2
  loop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (sh[0] == $past(loop_in)));

endmodule

// File: rtl/rx_deser.sv
module rx_deser
  import async_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic [3:0] nbits,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     done_o,
  output rx_char_t chr_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e             state;
  logic [CNT_W-1:0]      cnt;
  logic [3:0]            idx;
  logic [MAX_BITS-1:0]   shreg;
  logic                  zero_q;
  logic                  par_q;
  logic                  done_q;
  rx_char_t              chr_q;

  logic bit_mid;
  logic stop_low;
  logic all_low;
  assign bit_mid  = (cnt == LAST);
  assign stop_low = !line;
  assign all_low  = zero_q && stop_low;

  assign done_o = done_q;
  assign chr_o  = chr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      zero_q <= 1'b1;
      par_q  <= 1'b0;
      done_q <= 1'b0;
      chr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (state == ST_WAIT) begin
        if (line) state <= ST_IDLE;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!line) begin
              state  <= ST_START;
              cnt    <= '0;
              idx    <= '0;
              shreg  <= '0;
              zero_q <= 1'b1;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt   <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_mid) begin
              cnt        <= '0;
              shreg[idx] <= line;
              if (line) zero_q <= 1'b0;
              idx <= idx + 4'd1;
              if (idx == nbits - 4'd1) state <= par_en ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_mid) begin
              cnt   <= '0;
              par_q <= line;
              if (line) zero_q <= 1'b0;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_mid) begin
              cnt            <= '0;
              done_q         <= 1'b1;
              chr_q.data     <= shreg;
              chr_q.brk      <= all_low;
              chr_q.stop_bad <= stop_low && !zero_q;
              chr_q.par_bad  <= par_en && !all_low &&
                                (par_q != calc_parity(shreg, nbits, par_odd));
              state          <= line ? ST_IDLE : ST_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  start_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && cnt == MID && line) |=> (state == ST_IDLE));

  // R8
  brk_not_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !(chr_q.brk && chr_q.stop_bad));

  // R12
  wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !line) |=> (state == ST_WAIT));

endmodule

// File: rtl/rx_status.sv
module rx_status
  import async_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  rx_char_t   chr,
  input  logic       line,
  input  logic       buf_rd,
  input  logic       stat_rd,
  input  logic       attn_wr,
  input  logic       attn_wdata,
  input  logic       rie,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       buf_full,
  output logic       ovr_err,
  output logic       frm_err,
  output logic       par_err,
  output logic       brk_det,
  output logic       err_any,
  output logic       attn_mode,
  output logic       rx_active,
  output logic       rx_irq
);

  logic [MAX_BITS-1:0] buf_q;
  logic full_q, ovr_q, frm_q, par_q, brk_q, attn_q, act_q;

  // named internal events
  logic accept_evt, load_evt, ovr_evt, bad_line_evt;
  assign accept_evt   = done && !chr.brk && (!attn_q || chr.data[8]);
  assign load_evt     = accept_evt && (!full_q || buf_rd);
  assign ovr_evt      = accept_evt && full_q && !buf_rd;
  assign bad_line_evt = done && (chr.stop_bad || chr.brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
      brk_q  <= 1'b0;
      attn_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (load_evt) begin
        buf_q  <= chr.data;
        full_q <= 1'b1;
      end else if (buf_rd) begin
        full_q <= 1'b0;
      end
      ovr_q <= ovr_evt                    || (ovr_q && !stat_rd);
      frm_q <= (done && chr.stop_bad)     || (frm_q && !stat_rd);
      par_q <= (done && chr.par_bad)      || (par_q && !stat_rd);
      brk_q <= (done && chr.brk)          || (brk_q && !stat_rd);
      if (attn_wr)                    attn_q <= attn_wdata;
      else if (done && chr.data[8])   attn_q <= 1'b0;
      if (bad_line_evt)  act_q <= 1'b1;
      else if (line)     act_q <= 1'b0;
    end
  end

  assign rx_data   = buf_q[7:0];
  assign rx_bit9   = buf_q[8];
  assign buf_full  = full_q;
  assign ovr_err   = ovr_q;
  assign frm_err   = frm_q;
  assign par_err   = par_q;
  assign brk_det   = brk_q;
  assign err_any   = ovr_q | frm_q | par_q | brk_q;
  assign attn_mode = attn_q;
  assign rx_active = act_q;
  assign rx_irq    = full_q & rie;

  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ($stable(buf_q) && ovr_err));

  // R4
  rd_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !done) |=> !buf_full);

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> !(ovr_err || frm_err || par_err || brk_det));

  // R11
  attn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chr.data[8] && !attn_wr) |=> !attn_mode);

  // R12
  active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && line && !done) |=> !rx_active);

  // R13
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> !rx_irq);

  // R8
  brk_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chr.brk && !buf_rd) |=> $stable(buf_full));

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_pin,
  input  logic       tx_loop,
  input  logic [1:0] fmt_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rx_int_en,
  input  logic       buf_rd,
  input  logic       stat_rd,
  input  logic       attn_wr,
  input  logic       attn_wdata,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       buf_full,
  output logic       ovr_err,
  output logic       frm_err,
  output logic       par_err,
  output logic       brk_det,
  output logic       err_any,
  output logic       attn_mode,
  output logic       rx_active,
  output logic       rx_irq
);

  logic       loop_en;
  logic       line_s;
  logic [3:0] nbits;
  logic       done_w;
  rx_char_t   chr_w;

  assign loop_en = (fmt_sel == 2'b11);
  assign nbits   = fmt_bits(fmt_sel);

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_en (loop_en),
    .pin_in  (rx_pin),
    .loop_in (tx_loop),
    .line_o  (line_s)
  );

  rx_deser #(.OSR(OSR)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .line    (line_s),
    .nbits   (nbits),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done_o  (done_w),
    .chr_o   (chr_w)
  );

  rx_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done_w),
    .chr        (chr_w),
    .line       (line_s),
    .buf_rd     (buf_rd),
    .stat_rd    (stat_rd),
    .attn_wr    (attn_wr),
    .attn_wdata (attn_wdata),
    .rie        (rx_int_en),
    .rx_data    (rx_data),
    .rx_bit9    (rx_bit9),
    .buf_full   (buf_full),
    .ovr_err    (ovr_err),
    .frm_err    (frm_err),
    .par_err    (par_err),
    .brk_det    (brk_det),
    .err_any    (err_any),
    .attn_mode  (attn_mode),
    .rx_active  (rx_active),
    .rx_irq     (rx_irq)
  );

endmodule

// File: tb/tb_async_rx_core.sv
`timescale 1ns/1ps
module tb_async_rx_core;

  localparam int TICK_CLKS = 4;
  localparam int BIT_CLKS  = 16 * TICK_CLKS;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick;
  logic rx_pin = 1'b1, tx_loop = 1'b1;
  logic [1:0] fmt_sel = 2'b00;
  logic par_en = 1'b0, par_odd = 1'b0, rx_int_en = 1'b0;
  logic buf_rd = 1'b0, stat_rd = 1'b0, attn_wr = 1'b0, attn_wdata = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, buf_full, ovr_err, frm_err, par_err, brk_det, err_any;
  logic attn_mode, rx_active, rx_irq;

  int total = 0, fails = 0;
  int n_cnt, seen_at, pulse_at, pulse_kind;
  bit prev_full;
  int tcnt = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) tcnt <= (tcnt + 1) % TICK_CLKS;
  assign baud_tick = (tcnt == 0);

  async_rx_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .fmt_sel(fmt_sel), .par_en(par_en), .par_odd(par_odd),
    .rx_int_en(rx_int_en), .buf_rd(buf_rd), .stat_rd(stat_rd),
    .attn_wr(attn_wr), .attn_wdata(attn_wdata), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .buf_full(buf_full), .ovr_err(ovr_err),
    .frm_err(frm_err), .par_err(par_err), .brk_det(brk_det),
    .err_any(err_any), .attn_mode(attn_mode), .rx_active(rx_active),
    .rx_irq(rx_irq)
  );

  function automatic bit par_of(input logic [8:0] d, input int nb, input bit odd);
    bit p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  function automatic int bits_of(input logic [1:0] f);
    return (f == 2'b00) ? 8 : (f == 2'b01) ? 7 : 9;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_period(input bit v, input bit loop);
    if (loop) tx_loop = v; else rx_pin = v;
    for (int k = 0; k < BIT_CLKS; k++) begin
      @(negedge clk);
      n_cnt++;
      if (buf_full && !prev_full && seen_at < 0) seen_at = n_cnt;
      prev_full = buf_full;
      buf_rd  = (pulse_kind == 1 && n_cnt == pulse_at);
      stat_rd = (pulse_kind == 2 && n_cnt == pulse_at);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input bit pen,
                            input bit pbit, input bit stopv, input bit tailv,
                            input bit loop);
    @(negedge clk);
    while (tcnt != 0) @(negedge clk);
    n_cnt = 0; seen_at = -1; prev_full = buf_full;
    bit_period(1'b0, loop);
    for (int i = 0; i < nb; i++) bit_period(d[i], loop);
    if (pen) bit_period(pbit, loop);
    bit_period(stopv, loop);
    bit_period(tailv, loop);
    bit_period(tailv, loop);
    buf_rd = 1'b0; stat_rd = 1'b0; pulse_kind = 0;
  endtask

  task automatic pulse_buf_rd();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic pulse_stat_rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic write_attn(input bit v);
    @(negedge clk); attn_wr = 1'b1; attn_wdata = v;
    @(negedge clk); attn_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [8:0] d;
    int probe;
    pulse_kind = 0; pulse_at = -1;
    void'($urandom(32'd20241));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    check("R14 buf_full", buf_full, 0);
    check("R14 flags", {ovr_err, frm_err, par_err, brk_det, err_any}, 0);
    check("R14 attn/active/irq", {attn_mode, rx_active, rx_irq}, 0);
    check("R14 rx_data", rx_data, 0);

    // R1 seven-bit frame drops bit 7
    fmt_sel = 2'b01;
    send_frame(9'h0DA, 7, 0, 0, 1, 1, 0);
    check("R1 7-bit data", rx_data, 8'h5A);
    check("R1 7-bit bit9", rx_bit9, 0);
    check("R4 full after store", buf_full, 1);

    // R13 interrupt gating
    check("R13 irq masked", rx_irq, 0);
    rx_int_en = 1'b1; @(negedge clk);
    check("R13 irq raised", rx_irq, 1);

    // R5 overrun keeps old character; R10 summary
    fmt_sel = 2'b00;
    send_frame(9'h0C3, 8, 0, 0, 1, 1, 0);
    check("R5 ovr_err", ovr_err, 1);
    check("R5 old data kept", rx_data, 8'h5A);
    check("R10 err_any on", err_any, 1);
    pulse_stat_rd(); @(negedge clk);
    check("R9 ovr cleared", ovr_err, 0);
    check("R10 err_any off", err_any, 0);
    pulse_buf_rd(); @(negedge clk);
    check("R4 read empties", buf_full, 0);
    check("R13 irq drops", rx_irq, 0);
    rx_int_en = 1'b0;

    // R3 start glitch
    @(negedge clk);
    while (tcnt != 0) @(negedge clk);
    rx_pin = 1'b0;
    repeat (3 * TICK_CLKS) @(negedge clk);
    rx_pin = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R3 glitch no char", buf_full, 0);
    check("R3 glitch no flag", err_any, 0);

    // R7 parity
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(9'h0B1, 8, 1, !par_of(9'h0B1, 8, 0), 1, 1, 0);
    check("R7 even mismatch", par_err, 1);
    check("R7 stored anyway", rx_data, 8'hB1);
    pulse_stat_rd(); pulse_buf_rd();
    par_odd = 1'b1;
    send_frame(9'h0B1, 8, 1, par_of(9'h0B1, 8, 1), 1, 1, 0);
    check("R7 odd good", par_err, 0);
    pulse_buf_rd();
    par_en = 1'b0; par_odd = 1'b0;

    // R8 break
    send_frame(9'h000, 8, 0, 0, 0, 1, 0);
    check("R8 brk_det", brk_det, 1);
    check("R8 no frm", frm_err, 0);
    check("R8 not stored", buf_full, 0);
    pulse_stat_rd();

    // R6 / R12 framing error with line held low afterwards
    send_frame(9'h033, 8, 0, 0, 0, 0, 0);
    check("R6 frm_err", frm_err, 1);
    check("R6 stored", rx_data, 8'h33);
    check("R12 active while low", rx_active, 1);
    pulse_stat_rd(); pulse_buf_rd();
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R12 no restart while low", {buf_full, brk_det}, 0);
    rx_pin = 1'b1;
    repeat (8) @(negedge clk);
    check("R12 active falls", rx_active, 0);

    // R11 attention mode
    fmt_sel = 2'b10;
    write_attn(1'b1);
    check("R11 attn set", attn_mode, 1);
    send_frame(9'h0AA, 9, 0, 0, 1, 1, 0);
    check("R11 bit8 clear dropped", buf_full, 0);
    check("R11 attn held", attn_mode, 1);
    send_frame(9'h155, 9, 0, 0, 1, 1, 0);
    check("R11 bit8 set stored", {buf_full, rx_bit9, rx_data}, {1'b1, 1'b1, 8'h55});
    check("R11 attn cleared", attn_mode, 0);
    pulse_buf_rd();

    // R2 loopback ignores the pin
    fmt_sel = 2'b11;
    rx_pin = 1'b0;
    send_frame(9'h1C3, 9, 0, 0, 1, 1, 1);
    check("R2 loop data", {rx_bit9, rx_data}, 9'h1C3);
    check("R2 pin ignored", {rx_active, brk_det, frm_err}, 0);
    pulse_buf_rd();
    rx_pin = 1'b1;
    fmt_sel = 2'b00;
    repeat (2 * BIT_CLKS) @(negedge clk);

    // R4 coincident buffer read: probe the loading edge first
    send_frame(9'h011, 8, 0, 0, 1, 1, 0);
    probe = seen_at;
    pulse_kind = 1; pulse_at = probe - 1;
    send_frame(9'h0E7, 8, 0, 0, 1, 1, 0);
    check("R4 coincident read data", rx_data, 8'hE7);
    check("R4 coincident read full", buf_full, 1);
    check("R4 coincident no ovr", ovr_err, 0);
    pulse_buf_rd();

    // R9 coincident status read with framing error
    pulse_kind = 2; pulse_at = probe - 1;
    send_frame(9'h05C, 8, 0, 0, 0, 1, 0);
    check("R9 flag survives coincident read", frm_err, 1);
    pulse_stat_rd(); pulse_buf_rd();
    @(negedge clk);
    check("R9 cleared after read", frm_err, 0);

    // R1 / R7 random frames
    for (int t = 0; t < 16; t++) begin
      int nb;
      bit pe, po;
      fmt_sel = 2'($urandom % 3);
      nb = bits_of(fmt_sel);
      pe = 1'($urandom % 2); po = 1'($urandom % 2);
      par_en = pe; par_odd = po;
      d = 9'($urandom) & 9'((1 << nb) - 1);
      send_frame(d, nb, pe, par_of(d, nb, po), 1, 1, 0);
      check("R1 random data", {rx_bit9, rx_data}, d);
      check("R7 random parity ok", {par_err, frm_err, buf_full}, 3'b001);
      pulse_buf_rd(); pulse_stat_rd();
    end

    finish_run();
  end

endmodule